// File: doc/BRIEF.md
# Bus-Window Register File Controller

This block is a slave register bank on a 16-bit I/O bus. It sits between a host and a serial link to a remote workstation. It holds eight 16-bit words: control, interrupt reason, keyboard event, two function parameters, cursor X, cursor Y and interrupt vector. A word is selected by bits 3:1 of the bus address, so byte offsets 0, 2, … 14 select words 0 through 7, and address bit 0 is ignored.

Every host write that the bank accepts is stored and then forwarded to a link transmitter as a register-update message. The message carries the word index and the stored value. When a control write turns transmitting on, a transmit-on notice goes out before the update. When a control write turns transmitting off, a transmit-off notice follows the update. The link side reports remote transmit-on and transmit-off events. A change in link availability sets the transition bit and, if interrupts are enabled, raises an interrupt request. The acknowledge cycle returns word 7 as the vector.

A small sequencer emits the messages, one per cycle. It has four states:
- **IDLE**: no message.
- **SEND_ON**: transmit-on notice.
- **SEND_REG**: register update.
- **SEND_OFF**: transmit-off notice.

Its transitions are:
- IDLE→SEND_ON on an accepted write that raises transmit-on.
- IDLE→SEND_REG on any other accepted write.
- SEND_ON→SEND_REG always.
- SEND_REG→SEND_OFF when the write dropped transmit-on.
- SEND_REG→IDLE otherwise.
- SEND_OFF→IDLE always.

`bus_busy` is high outside IDLE.

Top module: `busin_regs`

## Requirements
- R1: After reset all eight words read 0, except word 1 (interrupt reason), which reads 0x0001. After reset `irq_req`, `tx_valid` and `bus_busy` are low.
- R2: The word index is `bus_addr[3:1]`. A read asserted with `bus_rd` at one clock edge presents that word on `bus_rdata` after that edge and holds it until the next read.
- R3: A write to word 0 while word 1 is nonzero changes no register and sends no message.
- R4: An accepted write stores the value and sends one register-update message. The message has `tx_kind`=3, `tx_index` equal to the word index and `tx_value` equal to the stored value. It appears the cycle after acceptance, or one cycle later when a transmit-on notice comes first.
- R5: A word-0 write that changes bit 12 (transmit on) from 0 to 1 sends a transmit-on notice (`tx_kind`=1) in the cycle immediately before the register update.
- R6: A word-0 write that changes bit 12 from 1 to 0 sends a transmit-off notice (`tx_kind`=2) in the cycle immediately after the register update. `tx_valid` drops in the following cycle.
- R7: A word-0 write with bit 15 (transition) written 0 stores bit 13 (link error) as 0, whatever value bit 13 had in the write data.
- R8: A remote transmit-on event sets word-0 bit 14 (link available). A remote transmit-off event clears bit 14. When bit 14 actually changes, bit 15 is set and, if bit 6 (interrupt enable) was set, `irq_req` rises. An event that leaves bit 14 unchanged sets neither bit 15 nor `irq_req`.
- R9: The pending interrupt is withdrawn in three cases: an accepted word-0 write drops a set bit 15; an accepted write of 0 goes to word 0 or word 1; or `irq_ack` is asserted. While `irq_ack` is high, `irq_vector` equals word 7.
- R10: `bus_busy` is high while messages are being sent. A write presented while `bus_busy` is high is ignored.
- R11: When a word-0 write and a link event fall in the same cycle, the event's effect on bits 14 and 15 is applied on top of the written value. An interrupt raised by the event wins over a withdrawal by the write.
- R12: Reads change no register, message or interrupt state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_addr | input | 4 | Byte address; bits 3:1 pick the word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| bus_busy | output | 1 | Message sequence in progress; writes ignored |
| lnk_rx_on | input | 1 | Remote transmit-on event |
| lnk_rx_off | input | 1 | Remote transmit-off event |
| irq_req | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq_vector | output | 16 | Word 7 during acknowledge, else 0 |
| tx_valid | output | 1 | Message valid this cycle |
| tx_kind | output | 2 | 1 transmit-on, 2 transmit-off, 3 register update |
| tx_index | output | 3 | Word index of an update |
| tx_value | output | 16 | Value of an update |

## Verification
A host write to the control word and a remote link event can land in the same clock edge. Both modify word 0, and the event may raise the interrupt while the write withdraws it. The bench provokes this on purpose, and also lets it occur in the random phase. Two directed cases cover it: one drives a transmit-on write together with a link-up event, and one drives a zero write together with a link-down event. The outcome is judged against a bench model that applies the write first and the event on top. The model computes the event's effect from the word-0 value before the edge. The bench then compares the resulting word 0, the interrupt line and the message order.

// File: rtl/busin_pkg.sv
package busin_pkg;
    localparam int unsigned CB_IE   = 6;
    localparam int unsigned CB_XMIT = 12;
    localparam int unsigned CB_LERR = 13;
    localparam int unsigned CB_LAV  = 14;
    localparam int unsigned CB_TRN  = 15;

    typedef enum logic [1:0] {
        TXK_NONE = 2'd0,
        TXK_ON   = 2'd1,
        TXK_OFF  = 2'd2,
        TXK_REG  = 2'd3
    } txk_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_SEND_ON,
        SQ_SEND_REG,
        SQ_SEND_OFF
    } sq_e;
endpackage

// File: rtl/busin_seq.sv
module busin_seq
    import busin_pkg::*;
#(
    parameter int unsigned DW = 16,
    parameter int unsigned IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          on_first,
    input  logic          off_last,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] val,
    output logic          busy,
    output logic          tx_valid,
    output logic [1:0]    tx_kind,
    output logic [IW-1:0] tx_index,
    output logic [DW-1:0] tx_value
);
    sq_e           st_q, st_n;
    logic [IW-1:0] idx_q;
    logic [DW-1:0] val_q;
    logic          off_q;

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            SQ_IDLE:     if (start) st_n = on_first ? SQ_SEND_ON : SQ_SEND_REG;
            SQ_SEND_ON:  st_n = SQ_SEND_REG;
            SQ_SEND_REG: st_n = off_q ? SQ_SEND_OFF : SQ_IDLE;
            SQ_SEND_OFF: st_n = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SQ_IDLE;
            idx_q <= '0;
            val_q <= '0;
            off_q <= 1'b0;
        end else begin
            st_q <= st_n;
            if (st_q == SQ_IDLE && start) begin
                idx_q <= idx;
                val_q <= val;
                off_q <= off_last;
            end
        end
    end

    always_comb begin
        tx_valid = 1'b1;
        tx_kind  = TXK_NONE;
        tx_index = '0;
        tx_value = '0;
        unique case (st_q)
            SQ_IDLE:     tx_valid = 1'b0;
            SQ_SEND_ON:  tx_kind  = TXK_ON;
            SQ_SEND_REG: begin
                tx_kind  = TXK_REG;
                tx_index = idx_q;
                tx_value = val_q;
            end
            SQ_SEND_OFF: tx_kind  = TXK_OFF;
        endcase
    end

    assign busy = (st_q != SQ_IDLE);
endmodule

// File: rtl/busin_bank.sv
module busin_bank
    import busin_pkg::*;
#(
    parameter int unsigned DW       = 16,
    parameter int unsigned NREG     = 8,
    parameter int unsigned IW       = 3,
    parameter int unsigned INIT_IDX = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wval,
    input  logic          withdraw,
    input  logic          rx_on,
    input  logic          rx_off,
    input  logic          ack,
    input  logic          rd,
    input  logic [IW-1:0] ridx,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] csr,
    output logic [DW-1:0] irr,
    output logic [DW-1:0] vec,
    output logic          irq
);
    logic [DW-1:0] regs_q [NREG];
    logic [DW-1:0] regs_n [NREG];
    logic [DW-1:0] rdata_q;
    logic          irq_q, irq_n;
    logic          lvl_chg, raise;

    assign lvl_chg = (rx_on && !regs_q[0][CB_LAV]) ||
                     (rx_off && !rx_on && regs_q[0][CB_LAV]);
    assign raise   = lvl_chg && regs_q[0][CB_IE];

    always_comb begin
        for (int i = 0; i < NREG; i++) regs_n[i] = regs_q[i];
        if (we) regs_n[widx] = wval;
        if (rx_on)       regs_n[0][CB_LAV] = 1'b1;
        else if (rx_off) regs_n[0][CB_LAV] = 1'b0;
        if (lvl_chg)     regs_n[0][CB_TRN] = 1'b1;
        irq_n = irq_q;
        if (withdraw || ack) irq_n = 1'b0;
        if (raise)           irq_n = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= DW'(i == INIT_IDX);
            irq_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= regs_n[i];
            irq_q <= irq_n;
            if (rd) rdata_q <= regs_q[ridx];
        end
    end

    assign rdata = rdata_q;
    assign csr   = regs_q[0];
    assign irr   = regs_q[1];
    assign vec   = regs_q[NREG-1];
    assign irq   = irq_q;
endmodule

// File: rtl/busin_regs.sv
module busin_regs
    import busin_pkg::*;
#(
    parameter int unsigned DW     = 16,
    parameter int unsigned NREG   = 8,
    parameter int unsigned IW     = $clog2(NREG),
    parameter int unsigned ADDR_W = IW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              bus_busy,
    input  logic              lnk_rx_on,
    input  logic              lnk_rx_off,
    output logic              irq_req,
    input  logic              irq_ack,
    output logic [DW-1:0]     irq_vector,
    output logic              tx_valid,
    output logic [1:0]        tx_kind,
    output logic [IW-1:0]     tx_index,
    output logic [DW-1:0]     tx_value
);
    logic [IW-1:0] idx;
    logic          is_ctl, accept, rise, fall, withdraw;
    logic [DW-1:0] wv, csr_w, irr_w, vec_w;

    assign idx    = bus_addr[ADDR_W-1:1];
    assign is_ctl = (idx == '0);
    assign accept = bus_wr && !bus_busy && (!is_ctl || irr_w == '0);
    assign rise   = is_ctl && bus_wdata[CB_XMIT] && !csr_w[CB_XMIT];
    assign fall   = is_ctl && !bus_wdata[CB_XMIT] && csr_w[CB_XMIT];

    always_comb begin
        wv = bus_wdata;
        if (is_ctl && !bus_wdata[CB_TRN]) wv[CB_LERR] = 1'b0;
    end

    assign withdraw = accept &&
        ((is_ctl && csr_w[CB_TRN] && !bus_wdata[CB_TRN]) ||
         (idx < IW'(2) && bus_wdata == '0));

    busin_bank #(.DW(DW), .NREG(NREG), .IW(IW), .INIT_IDX(1)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(accept), .widx(idx), .wval(wv),
        .withdraw(withdraw), .rx_on(lnk_rx_on), .rx_off(lnk_rx_off),
        .ack(irq_ack), .rd(bus_rd), .ridx(idx), .rdata(bus_rdata),
        .csr(csr_w), .irr(irr_w), .vec(vec_w), .irq(irq_req)
    );

    busin_seq #(.DW(DW), .IW(IW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(accept), .on_first(rise),
        .off_last(fall), .idx(idx), .val(wv), .busy(bus_busy),
        .tx_valid(tx_valid), .tx_kind(tx_kind), .tx_index(tx_index),
        .tx_value(tx_value)
    );

    assign irq_vector = irq_ack ? vec_w : '0;
endmodule

// File: rtl/busin_regs_chk.sv
module busin_regs_chk #(
    parameter int unsigned DW     = 16,
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_busy,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DW-1:0]     irr,
    input logic [DW-1:0]     csr,
    input logic              tx_valid,
    input logic [1:0]        tx_kind,
    input logic              irq_req,
    input logic              irq_ack,
    input logic              lnk_rx_on,
    input logic              lnk_rx_off
);
    p_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_busy && bus_addr[ADDR_W-1:1] == '0 && irr != '0) |=> !tx_valid);

    p_accept_sends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_busy && (bus_addr[ADDR_W-1:1] != '0 || irr == '0)) |=> tx_valid);

    p_on_before_reg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_kind == 2'd1) |=> (tx_valid && tx_kind == 2'd3));

    p_off_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_kind == 2'd2) |=> !tx_valid);

    p_irq_needs_ie_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(csr[6]));

    p_ack_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !lnk_rx_on && !lnk_rx_off) |=> !irq_req);
endmodule

bind busin_regs busin_regs_chk #(.DW(DW), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_busy(bus_busy),
    .bus_addr(bus_addr), .irr(irr_w), .csr(csr_w), .tx_valid(tx_valid),
    .tx_kind(tx_kind), .irq_req(irq_req), .irq_ack(irq_ack),
    .lnk_rx_on(lnk_rx_on), .lnk_rx_off(lnk_rx_off)
);

// File: tb/busin_regs_tb_top.sv
`timescale 1ns/1ps
module busin_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_busy;
    logic        lnk_rx_on = 1'b0, lnk_rx_off = 1'b0;
    logic        irq_req;
    logic        irq_ack = 1'b0;
    logic [15:0] irq_vector;
    logic        tx_valid;
    logic [1:0]  tx_kind;
    logic [2:0]  tx_index;
    logic [15:0] tx_value;

    int n_chk = 0, n_fail = 0;
    logic [15:0] m [8];
    bit mirq = 0;

    always #4 clk = ~clk;

    busin_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_busy(bus_busy), .lnk_rx_on(lnk_rx_on), .lnk_rx_off(lnk_rx_off),
        .irq_req(irq_req), .irq_ack(irq_ack), .irq_vector(irq_vector),
        .tx_valid(tx_valid), .tx_kind(tx_kind), .tx_index(tx_index),
        .tx_value(tx_value)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Link event effect on the model, judged against word 0 before the edge
    function automatic void apply_ev(input bit on, input bit off, input logic [15:0] old);
        if (on) begin
            if (!old[14]) begin m[0][15] = 1'b1; if (old[6]) mirq = 1; end
            m[0][14] = 1'b1;
        end else if (off) begin
            if (old[14]) begin m[0][15] = 1'b1; if (old[6]) mirq = 1; end
            m[0][14] = 1'b0;
        end
    endfunction

    task automatic do_rd(input int idx);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = {idx[2:0], 1'($urandom_range(0, 1))};
        @(negedge clk);
        bus_rd = 1'b0;
        chk(bus_rdata == m[idx], "R2", {16'b0, bus_rdata}, {16'b0, m[idx]});
        chk(tx_valid == 1'b0 && irq_req == mirq, "R12", {30'b0, tx_valid, irq_req}, {31'b0, mirq});
    endtask

    task automatic do_wr(input int idx, input logic [15:0] d, input bit on, input bit off, input bit intrude);
        logic [15:0] old, wd;
        bit acc;
        logic [1:0] ek [3];
        int n = 0;
        old = m[0];
        acc = (idx != 0) || (m[1] == 16'h0);
        wd = d;
        if (idx == 0 && !d[15]) wd[13] = 1'b0;
        if (acc) begin
            if (idx == 0 && d[12] && !old[12]) begin ek[n] = 2'd1; n++; end
            ek[n] = 2'd3; n++;
            if (idx == 0 && old[12] && !d[12]) begin ek[n] = 2'd2; n++; end
            m[idx] = wd;
            if ((idx == 0 && old[15] && !d[15]) || (idx <= 1 && d == 16'h0)) mirq = 0;
        end
        apply_ev(on, off, old);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = {idx[2:0], 1'($urandom_range(0, 1))}; bus_wdata = d;
        lnk_rx_on = on; lnk_rx_off = off;
        @(negedge clk);
        bus_wr = 1'b0; lnk_rx_on = 1'b0; lnk_rx_off = 1'b0;
        if (!acc) chk(!tx_valid && !bus_busy, "R3", {30'b0, tx_valid, bus_busy}, 32'h0);
        for (int k = 0; k < n; k++) begin
            chk(tx_valid && tx_kind == ek[k] &&
                (ek[k] != 2'd3 || (tx_index == idx[2:0] && tx_value == wd)),
                ek[k] == 2'd1 ? "R5" : (ek[k] == 2'd2 ? "R6" : "R4"),
                {10'b0, tx_valid, tx_kind, tx_index, tx_value},
                {10'b0, 1'b1, ek[k], idx[2:0], wd});
            chk(bus_busy, "R10", {31'b0, bus_busy}, 32'h1);
            if (k == 0 && intrude) begin
                bus_wr = 1'b1; bus_addr = 4'h4; bus_wdata = 16'hDEAD;
            end
            @(negedge clk);
            bus_wr = 1'b0;
        end
        chk(!tx_valid && !bus_busy, "R6", {30'b0, tx_valid, bus_busy}, 32'h0);
        chk(irq_req == mirq, on || off ? "R11" : "R9", {31'b0, irq_req}, {31'b0, mirq});
    endtask

    task automatic do_ev(input bit on, input bit off);
        logic [15:0] old;
        old = m[0];
        apply_ev(on, off, old);
        @(negedge clk);
        lnk_rx_on = on; lnk_rx_off = off;
        @(negedge clk);
        lnk_rx_on = 1'b0; lnk_rx_off = 1'b0;
        chk(irq_req == mirq, "R8", {31'b0, irq_req}, {31'b0, mirq});
    endtask

    task automatic do_ack();
        @(negedge clk);
        irq_ack = 1'b1;
        #2;
        chk(irq_vector == m[7], "R9", {16'b0, irq_vector}, {16'b0, m[7]});
        @(negedge clk);
        irq_ack = 1'b0;
        mirq = 0;
        chk(irq_req == 1'b0, "R9", {31'b0, irq_req}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int i = 0; i < 8; i++) m[i] = (i == 1) ? 16'h1 : 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!irq_req && !tx_valid && !bus_busy, "R1", {29'b0, irq_req, tx_valid, bus_busy}, 32'h0);
        for (int i = 0; i < 8; i++) do_rd(i);                  // R1 reset contents
        do_wr(0, 16'h1040, 0, 0, 0);                          // R3 locked by word 1
        do_rd(0);
        do_wr(1, 16'h0000, 0, 0, 0);                          // R4 unlock
        do_wr(0, 16'h1040, 0, 0, 1);                          // R5 on-notice, R10 intruding write
        do_rd(2);                                             // R10 intrusion ignored
        do_wr(7, 16'h00A8, 0, 0, 0);
        do_ev(1, 0);                                          // R8 link up, irq
        do_rd(0);
        do_ack();                                             // R9 vector and withdrawal
        do_ev(1, 0);                                          // R8 no change, no irq
        do_rd(0);
        do_wr(0, 16'hF040, 0, 0, 0);                          // keeps error bit with bit15 set
        do_rd(0);
        do_ev(0, 1);                                          // R8 link down
        do_wr(0, 16'h2040, 0, 0, 0);                          // R7 error cleared, R6 off-notice, R9 withdraw
        do_rd(0);
        do_wr(0, 16'h1040, 1, 0, 0);                          // R11 write + link up
        do_rd(0);
        do_wr(0, 16'h0000, 0, 1, 0);                          // R11 zero write + link down, set wins
        do_rd(0);
        for (int it = 0; it < 400; it++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 4) begin
                int ix;
                logic [15:0] d;
                ix = $urandom_range(0, 7);
                d = 16'($urandom);
                if (ix == 1 && $urandom_range(0, 1) == 0) d = 16'h0;
                do_wr(ix, d, $urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0, 0);
            end else if (op < 7) do_rd($urandom_range(0, 7));
            else if (op < 9) do_ev($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
            else do_ack();
        end
        for (int i = 0; i < 8; i++) do_rd(i);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule